// File: doc/BRIEF.md
# Receive FIFO Timeout Timer

This block makes sure that characters sitting in a receive FIFO below its interrupt trigger level still reach the host. While the FIFO holds data and nothing new arrives, it counts elapsed bit times. When the count reaches a limit set by the configured character length, it raises a timeout interrupt request. The limit is four character lengths plus twelve bit times.

Bit times come from the receiver's own oversampling tick, divided by 16 or by 8 depending on the oversampling mode. Any received character, and any host read, restarts the measurement. A host read also clears a pending timeout, and so does the FIFO becoming empty. The request is gated by the same enable that the receive data-ready interrupt uses.

Top module: `rx_fifo_timeout`

## Requirements
- R1: The timeout threshold is 4*(5+len_code)+12 bit times. The codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, which gives 32, 36, 40 or 44 bit times. With the FIFO non-empty from a cleared state and a tick on every cycle, the request appears after exactly threshold*divider clock edges.
- R2: One bit time is 16 oversampling ticks when os_mode is 0 and 8 ticks when os_mode is 1. Clock cycles without os_tick do not advance the timer.
- R3: While fifo_nonempty is 0, the timer is held at zero and no timeout is pending. A pending timeout is cleared on the edge at which the FIFO is seen empty.
- R4: A char_rx pulse restarts the measurement, including the partial bit time. A pending timeout is left as it is.
- R5: A host_rd pulse restarts the measurement and clears a pending timeout on that edge.
- R6: tmo_irq is high only while a timeout is pending and int_en is 1. int_en does not affect timing: a timeout that becomes pending while disabled shows as soon as int_en goes to 1.
- R7: A pending timeout stays pending until a host read or an empty FIFO clears it.
- R8: After a synchronous active-low reset, tmo_irq is 0 and the timer is at zero.
- R9: If len_code changes to a threshold that is at or below the bit times already counted, the timeout becomes pending at the next completed bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, one cycle wide |
| os_mode | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| len_code | input | 2 | Character length code, 0..3 for 5..8 data bits |
| fifo_nonempty | input | 1 | High while the receive FIFO holds data |
| char_rx | input | 1 | Pulse when a character enters the FIFO |
| host_rd | input | 1 | Pulse when the host reads the FIFO |
| int_en | input | 1 | Shared receive-data interrupt enable |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
The case hardest to reach is a character length shrinking below time already spent. The bench first lets the timer run 40 bit times at the 8-bit length. It then switches to the 5-bit code and requires the request within one bit time. A second hard case is a timeout that becomes pending while the interrupt is disabled. The bench holds int_en low past the threshold and then raises it, and the request must appear at once. Exact latencies are measured for every length code in both oversampling modes. A long random phase is compared against a behavioural model on every clock.

// File: rtl/rxto_pkg.sv
// Package: shared types for the receive FIFO timeout timer.
// Assumes nothing beyond the standard types.
package rxto_pkg;
    // Oversampling ratio select
    typedef enum logic {
        OS_X16 = 1'b0,
        OS_X8  = 1'b1
    } os_mode_e;
endpackage

// File: rtl/rxto_bit_div.sv
// Module: rxto_bit_div
// Divides the oversampling tick into one pulse per bit time.
// Assumes os_tick is a one-cycle strobe. A restart clears the partial bit.
// If the mode switches to the shorter ratio with the phase past its end,
// the next tick completes the bit.
module rxto_bit_div #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic os_mode,
    input  logic restart,
    output logic bit_pulse
);
    import rxto_pkg::*;

    localparam int PH_W = (OS_HI > 1) ? $clog2(OS_HI) : 1;
    localparam logic [PH_W-1:0] TERM_HI = PH_W'(OS_HI - 1);
    localparam logic [PH_W-1:0] TERM_LO = PH_W'(OS_LO - 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] term;
    logic            at_end;

    // Pick the last phase of a bit for the active ratio
    always_comb begin
        term = (os_mode_e'(os_mode) == OS_X8) ? TERM_LO : TERM_HI;
    end

    assign at_end    = (phase >= term);
    assign bit_pulse = os_tick && !restart && at_end;

    // Advance the phase on each tick; wrap at the end of a bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (os_tick) begin
            phase <= at_end ? '0 : phase + 1'b1;
        end
    end

    assert_wrap_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pulse |=> (phase == '0));

    assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/rxto_limit.sv
// Module: rxto_limit
// Works out the timeout threshold in bit times from the length code:
// WORDS character lengths plus EXTRA bit times.
// Assumes code k means LEN_BASE+k data bits.
module rxto_limit #(
    parameter int LEN_W    = 2,
    parameter int LEN_BASE = 5,
    parameter int WORDS    = 4,
    parameter int EXTRA    = 12,
    parameter int CNT_W    = 6
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [CNT_W-1:0] limit
);
    // Threshold arithmetic in integer width, then narrowed
    always_comb begin
        int bits;
        bits  = WORDS * (LEN_BASE + int'(len_code)) + EXTRA;
        limit = CNT_W'(bits);
    end
endmodule

// File: rtl/rxto_timer.sv
// Module: rxto_timer
// Counts bit times while the FIFO holds data. Keeps the pending-timeout flag.
// Assumes the limit is at least 1. The count stops at the limit.
module rxto_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_pulse,
    input  logic             restart,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             pending
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next;
    logic             reach;

    assign cnt_next = {1'b0, cnt} + 1'b1;
    assign reach    = bit_pulse && (cnt_next >= {1'b0, limit});

    // Elapsed bit-time counter, held at zero by any restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (bit_pulse && (cnt < limit)) begin
            cnt <= cnt_next[CNT_W-1:0];
        end
    end

    // Pending flag: set on reaching the limit, cleared by read or empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (clear) begin
            pending <= 1'b0;
        end else if (reach && !restart) begin
            pending <= 1'b1;
        end
    end

    assert_rise_on_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(bit_pulse));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!pending && cnt == '0));

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !clear) |=> (cnt == '0 && pending == $past(pending)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear) |=> pending);
endmodule

// File: rtl/rx_fifo_timeout.sv
// Module: rx_fifo_timeout (top)
// Receive FIFO timeout timer. It raises a request when data has sat in the
// FIFO for a length-dependent number of bit times with no new character
// and no host read. Assumes all inputs are synchronous to clk.
module rx_fifo_timeout #(
    parameter int OS_HI    = 16,
    parameter int OS_LO    = 8,
    parameter int LEN_W    = 2,
    parameter int LEN_BASE = 5,
    parameter int WORDS    = 4,
    parameter int EXTRA    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             os_mode,
    input  logic [LEN_W-1:0] len_code,
    input  logic             fifo_nonempty,
    input  logic             char_rx,
    input  logic             host_rd,
    input  logic             int_en,
    output logic             tmo_irq
);
    localparam int LIM_MAX = WORDS * (LEN_BASE + (1 << LEN_W) - 1) + EXTRA;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    logic             restart;
    logic             clear;
    logic             bit_pulse;
    logic             pending;
    logic [CNT_W-1:0] limit;

    // Restart on any activity or an empty FIFO; clear only on read or empty
    assign restart = char_rx || host_rd || !fifo_nonempty;
    assign clear   = host_rd || !fifo_nonempty;

    rxto_bit_div #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_div (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
        .restart(restart), .bit_pulse(bit_pulse)
    );

    rxto_limit #(.LEN_W(LEN_W), .LEN_BASE(LEN_BASE), .WORDS(WORDS),
                 .EXTRA(EXTRA), .CNT_W(CNT_W)) u_lim (
        .len_code(len_code), .limit(limit)
    );

    rxto_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .bit_pulse(bit_pulse), .restart(restart),
        .clear(clear), .limit(limit), .pending(pending)
    );

    // Gate the request with the shared receive interrupt enable
    assign tmo_irq = pending && int_en;

    assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !tmo_irq);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> !tmo_irq);

    assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_irq && int_en && fifo_nonempty && !host_rd) |=> (tmo_irq || !int_en));
endmodule

// File: tb/sim_rx_fifo_timeout.sv
`timescale 1ns/1ps
module sim_rx_fifo_timeout;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       os_mode = 1'b0;
    logic [1:0] len_code = 2'd0;
    logic       fifo_nonempty = 1'b0;
    logic       char_rx = 1'b0;
    logic       host_rd = 1'b0;
    logic       int_en = 1'b1;
    logic       tmo_irq;

    int checks = 0;
    int errors = 0;
    string tag = "R8";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_fifo_timeout u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .os_mode(os_mode),
        .len_code(len_code), .fifo_nonempty(fifo_nonempty), .char_rx(char_rx),
        .host_rd(host_rd), .int_en(int_en), .tmo_irq(tmo_irq)
    );

    // Behavioural reference: phase within bit, bits elapsed, pending flag
    int m_phase = 0, m_bits = 0;
    bit m_pend = 0;
    always @(posedge clk) begin
        int div, lim;
        bit rs, pulse;
        div = os_mode ? 8 : 16;
        lim = 4 * (5 + len_code) + 12;
        rs = char_rx || host_rd || !fifo_nonempty;
        pulse = os_tick && !rs && (m_phase >= div - 1);
        if (!rst_n) begin
            m_phase = 0; m_bits = 0; m_pend = 0;
        end else begin
            if (host_rd || !fifo_nonempty) m_pend = 0;
            else if (pulse && !rs && m_bits + 1 >= lim) m_pend = 1;
            if (rs) begin m_phase = 0; m_bits = 0; end
            else begin
                if (pulse && m_bits < lim) m_bits = m_bits + 1;
                if (os_tick) m_phase = (m_phase >= div - 1) ? 0 : m_phase + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock; compare the output against the model away from the edge
    task automatic step();
        @(negedge clk);
        chk(tmo_irq === (m_pend && int_en), tag, int'(tmo_irq), int'(m_pend && int_en));
    endtask

    // Empty the FIFO for one edge, then start timing from zero
    task automatic fresh(input bit mode, input logic [1:0] code);
        fifo_nonempty = 1'b0; os_tick = 1'b1; os_mode = mode; len_code = code;
        step();
        fifo_nonempty = 1'b1;
    endtask

    task automatic count_to_irq(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            step(); n++;
            if (tmo_irq) break;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(tmo_irq === 1'b0, "R8", int'(tmo_irq), 0);
        rst_n = 1'b1;
        step();

        // R1 / R2: exact latency for every code, both ratios
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                int exp;
                tag = "R1";
                exp = (4 * (5 + c) + 12) * (m ? 8 : 16);
                fresh(m[0], 2'(c));
                count_to_irq(2000, n);
                chk(n == exp, (m ? "R2" : "R1"), n, exp);
            end
        end

        // R2: ticks every other cycle double the latency
        tag = "R2";
        fresh(1'b1, 2'd0);
        n = 0;
        while (n < 2000) begin
            os_tick = n[0];
            step(); n++;
            if (tmo_irq) break;
        end
        chk(n == 512, "R2", n, 512);
        os_tick = 1'b1;

        // R7 and R4: stays pending through new characters
        tag = "R7";
        char_rx = 1'b1; step(); char_rx = 1'b0;
        repeat (300) step();
        chk(tmo_irq === 1'b1, "R4", int'(tmo_irq), 1);

        // R5: a host read clears it
        tag = "R5";
        host_rd = 1'b1; step(); host_rd = 1'b0;
        chk(tmo_irq === 1'b0, "R5", int'(tmo_irq), 0);
        count_to_irq(2000, n);
        chk(n == 256, "R5", n, 256);

        // R4: a character mid-count restarts the full interval
        tag = "R4";
        fresh(1'b0, 2'd0);
        repeat (400) step();
        char_rx = 1'b1; step(); char_rx = 1'b0;
        count_to_irq(2000, n);
        chk(n == 512, "R4", n, 512);

        // R3: the FIFO emptying clears it; nothing while empty
        tag = "R3";
        fifo_nonempty = 1'b0; step();
        chk(tmo_irq === 1'b0, "R3", int'(tmo_irq), 0);
        repeat (1000) step();
        chk(tmo_irq === 1'b0, "R3", int'(tmo_irq), 0);

        // R6: pending while disabled, shown when enabled
        tag = "R6";
        int_en = 1'b0;
        fresh(1'b1, 2'd0);
        repeat (300) step();
        chk(tmo_irq === 1'b0, "R6", int'(tmo_irq), 0);
        int_en = 1'b1; #1;
        chk(tmo_irq === 1'b1, "R6", int'(tmo_irq), 1);

        // R9: shrink the length below the elapsed time
        tag = "R9";
        fresh(1'b1, 2'd3);
        repeat (320) step();
        chk(tmo_irq === 1'b0, "R9", int'(tmo_irq), 0);
        len_code = 2'd0;
        count_to_irq(100, n);
        chk(n >= 1 && n <= 8, "R9", n, 8);

        // Random phase against the model
        tag = "R1";
        for (int i = 0; i < 6000; i++) begin
            os_tick = 1'($urandom % 2);
            char_rx = (($urandom % 1500) == 0);
            host_rd = (($urandom % 1500) == 0);
            fifo_nonempty = (($urandom % 800) != 0);
            if (($urandom % 700) == 0) int_en = ~int_en;
            if (($urandom % 900) == 0) len_code = 2'($urandom % 4);
            if (($urandom % 1100) == 0) os_mode = ~os_mode;
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule